// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block produces the sequence of element addresses for one DMA channel. Software sets up a start address, an inner (row) count, an outer (row-number) count, two signed steps and an element size on plain configuration pins, then pulses `start`. The block captures that setup and offers one address at a time on a valid/ready stream. The address moves by the inner step inside a row and by the outer step after the last element of a row. The outer step may be smaller than the inner one, zero or negative, so interleaved streams can be pulled apart as they pass.

Two modes are available. In stop mode one frame is walked and the block goes idle with a `done` pulse. In autobuffer mode it reloads its start address and both counts at the end of each frame and carries on. An interrupt pulse marks either each finished frame or each finished row. With 2D disabled, only the inner count and step matter.

Back-pressure: `addr_valid` stays high for as long as the block is busy. An element is accepted only in a cycle where `addr_valid` and `addr_ready` are both high. While `addr_ready` is low the offered address does not change. The consumer may hold `addr_ready` high all the time.

Top module: `dma2d_agen`

## Requirements
- R1: After reset `addr_valid`, `busy`, `done` and `irq` are all low.
- R2: A `start` pulse while idle captures the configuration. From the next cycle `addr_valid` is high and `addr_data` equals the captured start address.
- R3: While `addr_valid` is high and `addr_ready` is low, `addr_valid` stays high and `addr_data` holds its value in the next cycle.
- R4: Inside a row, each accepted element advances the address by the inner step times the element size. The step is signed 16-bit, and `cfg_esize` 0, 1 and 2 mean 1, 2 and 4 bytes (3 is taken as 4).
- R5: In 2D mode, the element that ends a row (not the last row) advances the address by the signed outer step times the element size, and this may be zero or negative.
- R6: With `cfg_two_d` low, one frame is exactly the inner count of elements, and the outer count and outer step have no effect.
- R7: A count value of 0 stands for 65536 elements.
- R8: In stop mode, accepting the last element of a frame gives a one-cycle `done` pulse in the next cycle. In that same cycle `addr_valid` and `busy` are low.
- R9: In autobuffer mode, the element after the last one of a frame has the start address again and both counts are reloaded. `done` never rises and `addr_valid` stays high.
- R10: With `cfg_irq_row` low, `irq` pulses for one cycle after the last element of each frame and at no other time.
- R11: With `cfg_irq_row` high, `irq` pulses for one cycle after the last element of every row, the frame's last row included.
- R12: A `start` pulse while busy is ignored, and the address sequence carries on from the captured setup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start_addr | input | 32 | Byte address of the first element |
| cfg_x_count | input | 16 | Elements per row (0 means 65536) |
| cfg_y_count | input | 16 | Rows per frame in 2D mode (0 means 65536) |
| cfg_x_step | input | 16 | Signed inner step, in elements |
| cfg_y_step | input | 16 | Signed outer step, in elements |
| cfg_esize | input | 2 | Element size: 0 = 1 B, 1 = 2 B, 2 or 3 = 4 B |
| cfg_two_d | input | 1 | 1 enables 2D walking |
| cfg_auto | input | 1 | 1 selects autobuffer, 0 selects stop |
| cfg_irq_row | input | 1 | 1 interrupts per row, 0 per frame |
| start | input | 1 | One-cycle start request |
| addr_valid | output | 1 | Address offered |
| addr_ready | input | 1 | Consumer accepts the offered address |
| addr_data | output | 32 | Current element address |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle end-of-transfer pulse (stop mode) |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The hardest situation to reach is the zero-count case, because it needs a full 65536-element frame to run to its end before `done` can show that the count was taken as 65536. The bench gets there by holding `addr_ready` high throughout and walking the whole row in 1D mode. It also checks every address on the way. A second corner that takes care to reach is a restart request that arrives mid-frame. The bench raises `start` with a different start address in the middle of an autobuffer walk and checks that the sequence, including the reload to the original start address, does not change.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  typedef enum logic [1:0] {
    ES_BYTE = 2'd0,
    ES_HALF = 2'd1,
    ES_WORD = 2'd2,
    ES_WRD2 = 2'd3
  } esize_e;

  // shift amount applied to a step for a given element size
  function automatic logic [1:0] esize_shift(input logic [1:0] code);
    case (code)
      ES_BYTE: esize_shift = 2'd0;
      ES_HALF: esize_shift = 2'd1;
      default: esize_shift = 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/dma2d_step_scale.sv
module dma2d_step_scale #(
  parameter int SW = 16,
  parameter int AW = 32
) (
  input  logic [SW-1:0] step,
  input  logic [1:0]    esize,
  output logic [AW-1:0] delta
);
  import dma2d_pkg::*;
  localparam int EXT = AW - SW;

  logic [AW-1:0] ext;
  logic [1:0]    sh;

  generate
    if (EXT > 0) begin : g_ext
      assign ext = {{EXT{step[SW-1]}}, step};
    end else begin : g_trunc
      assign ext = step[AW-1:0];
    end
  endgenerate

  always_comb begin
    sh    = esize_shift(esize);
    delta = ext << sh;
  end
endmodule

// File: rtl/dma2d_cnt.sv
module dma2d_cnt #(
  parameter int CW = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [CW:0] load_val,
  input  logic        dec,
  output logic [CW:0] rem,
  output logic        at_one
);
  logic [CW:0] rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rem_q <= '0;
    else if (load) rem_q <= load_val;
    else if (dec)  rem_q <= rem_q - 1'b1;
  end

  assign rem    = rem_q;
  assign at_one = (rem_q == {{CW{1'b0}}, 1'b1});
endmodule

// File: rtl/dma2d_agen.sv
module dma2d_agen #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_start_addr,
  input  logic [CW-1:0] cfg_x_count,
  input  logic [CW-1:0] cfg_y_count,
  input  logic [SW-1:0] cfg_x_step,
  input  logic [SW-1:0] cfg_y_step,
  input  logic [1:0]    cfg_esize,
  input  logic          cfg_two_d,
  input  logic          cfg_auto,
  input  logic          cfg_irq_row,
  input  logic          start,
  output logic          addr_valid,
  input  logic          addr_ready,
  output logic [AW-1:0] addr_data,
  output logic          busy,
  output logic          done,
  output logic          irq
);
  localparam logic [CW:0] FULL_CNT = {1'b1, {CW{1'b0}}};

  logic          busy_q, auto_q, twod_q, irqrow_q, done_q, irq_q;
  logic [AW-1:0] base_q, addr_q, xinc_q, yinc_q;
  logic [CW:0]   xload_q, yload_q;
  logic [AW-1:0] xinc_d, yinc_d;
  logic [CW:0]   xeff, yeff;
  logic [CW:0]   xrem, yrem;
  logic          x_last, y_last;
  logic          take, hs, row_end, frame_end;

  // zero count means the full 2^CW range
  assign xeff = (cfg_x_count == '0) ? FULL_CNT : {1'b0, cfg_x_count};
  assign yeff = (cfg_y_count == '0) ? FULL_CNT : {1'b0, cfg_y_count};

  dma2d_step_scale #(.SW(SW), .AW(AW)) u_xs (
    .step(cfg_x_step), .esize(cfg_esize), .delta(xinc_d));
  dma2d_step_scale #(.SW(SW), .AW(AW)) u_ys (
    .step(cfg_y_step), .esize(cfg_esize), .delta(yinc_d));

  assign take      = start & ~busy_q;
  assign hs        = busy_q & addr_ready;
  assign row_end   = x_last;
  assign frame_end = x_last & (~twod_q | y_last);

  dma2d_cnt #(.CW(CW)) u_xcnt (
    .clk(clk), .rst_n(rst_n),
    .load(take | (hs & row_end)),
    .load_val(take ? xeff : xload_q),
    .dec(hs & ~row_end),
    .rem(xrem), .at_one(x_last));

  dma2d_cnt #(.CW(CW)) u_ycnt (
    .clk(clk), .rst_n(rst_n),
    .load(take | (hs & frame_end)),
    .load_val(take ? yeff : yload_q),
    .dec(hs & row_end & ~frame_end),
    .rem(yrem), .at_one(y_last));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      auto_q   <= 1'b0;
      twod_q   <= 1'b0;
      irqrow_q <= 1'b0;
      base_q   <= '0;
      addr_q   <= '0;
      xinc_q   <= '0;
      yinc_q   <= '0;
      xload_q  <= '0;
      yload_q  <= '0;
      done_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      done_q <= hs & frame_end & ~auto_q;
      irq_q  <= hs & (frame_end | (row_end & irqrow_q));
      if (take) begin
        busy_q   <= 1'b1;
        auto_q   <= cfg_auto;
        twod_q   <= cfg_two_d;
        irqrow_q <= cfg_irq_row;
        base_q   <= cfg_start_addr;
        addr_q   <= cfg_start_addr;
        xinc_q   <= xinc_d;
        yinc_q   <= yinc_d;
        xload_q  <= xeff;
        yload_q  <= yeff;
      end else if (hs) begin
        if (frame_end) begin
          addr_q <= base_q;
          if (!auto_q) busy_q <= 1'b0;
        end else if (row_end) begin
          addr_q <= addr_q + yinc_q;
        end else begin
          addr_q <= addr_q + xinc_q;
        end
      end
    end
  end

  assign addr_valid = busy_q;
  assign addr_data  = addr_q;
  assign busy       = busy_q;
  assign done       = done_q;
  assign irq        = irq_q;
endmodule

// File: rtl/dma2d_agen_chk.sv
module dma2d_agen_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [AW-1:0] cfg_start_addr,
  input logic          addr_valid,
  input logic          addr_ready,
  input logic [AW-1:0] addr_data,
  input logic          busy,
  input logic          done,
  input logic          auto_q
);
  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && !addr_ready |=> addr_valid && $stable(addr_data));

  // R2
  start_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> addr_valid && addr_data == $past(cfg_start_addr));

  // R8
  done_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(addr_valid && addr_ready) && !busy && !addr_valid);

  // R9
  auto_never_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && auto_q |=> !done && busy);

  // R12
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !addr_ready |=> $stable(addr_data));
endmodule

bind dma2d_agen dma2d_agen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cfg_start_addr(cfg_start_addr),
  .addr_valid(addr_valid), .addr_ready(addr_ready), .addr_data(addr_data),
  .busy(busy), .done(done), .auto_q(auto_q));

// File: tb/dma2d_agen_test.sv
module dma2d_agen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_start_addr = '0;
  logic [15:0] cfg_x_count = '0, cfg_y_count = '0;
  logic [15:0] cfg_x_step = '0, cfg_y_step = '0;
  logic [1:0]  cfg_esize = '0;
  logic        cfg_two_d = 1'b0, cfg_auto = 1'b0, cfg_irq_row = 1'b0;
  logic        start = 1'b0, addr_ready = 1'b1;
  logic        addr_valid, busy, done, irq;
  logic [31:0] addr_data;
  int n_cmp = 0, n_bad = 0;

  always #5 clk = ~clk;

  dma2d_agen uut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0; addr_ready = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic setup(input logic [31:0] base, input int nx, input int ny,
                       input int sx, input int sy, input int es, input bit two_d,
                       input bit auto_m, input bit irow);
    cfg_start_addr = base; cfg_x_count = 16'(nx); cfg_y_count = 16'(ny);
    cfg_x_step = 16'(sx); cfg_y_step = 16'(sy); cfg_esize = 2'(es);
    cfg_two_d = two_d; cfg_auto = auto_m; cfg_irq_row = irow;
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // walk one or more frames with a bench model; ready held high except at bp_at
  task automatic walk(input string req, input int nx, input int ny, input int passes,
                      input int bp_at, input int restart_at);
    logic [31:0] base = cfg_start_addr;
    logic [31:0] a = cfg_start_addr;
    int bytes = (cfg_esize == 2'd0) ? 1 : (cfg_esize == 2'd1) ? 2 : 4;
    int sx = int'($signed(cfg_x_step)) * bytes;
    int sy = int'($signed(cfg_y_step)) * bytes;
    bit auto_m = cfg_auto, irow = cfg_irq_row;
    bit p_irq = 1'b0, p_done = 1'b0;
    int idx = 0;
    for (int p = 0; p < passes; p++) begin
      for (int y = 0; y < ny; y++) begin
        for (int x = 0; x < nx; x++) begin
          if (idx > 0) @(negedge clk);
          start = 1'b0;
          chk(irq == p_irq, irow ? "R11" : "R10", "irq", irq, p_irq);
          chk(done == p_done, "R8", "done", done, p_done);
          if (idx == bp_at) begin
            addr_ready = 1'b0;
            for (int k = 0; k < 3; k++) begin
              @(negedge clk);
              chk(addr_valid && addr_data == a, "R3", "held addr", addr_data, a);
              chk(irq == 1'b0, "R3", "irq in stall", irq, 0);
            end
            addr_ready = 1'b1;
          end
          chk(addr_valid == 1'b1, req, "valid", addr_valid, 1);
          chk(addr_data == a, req, "addr", addr_data, a);
          if (idx == restart_at) begin
            start = 1'b1;
            cfg_start_addr = base ^ 32'h00F0_0000;
          end
          p_done = 1'b0;
          if (x == nx - 1 && y == ny - 1) begin
            a = base; p_irq = 1'b1; p_done = !auto_m;
          end else if (x == nx - 1) begin
            a = a + 32'(sy); p_irq = irow;
          end else begin
            a = a + 32'(sx); p_irq = 1'b0;
          end
          idx++;
        end
      end
    end
    @(negedge clk);
    start = 1'b0;
    chk(irq == 1'b1, irow ? "R11" : "R10", "frame irq", irq, 1);
    if (!auto_m) begin
      chk(done == 1'b1, "R8", "done pulse", done, 1);
      chk(!addr_valid && !busy, "R8", "idle after done", {addr_valid, busy}, 0);
      @(negedge clk);
      chk(done == 1'b0, "R8", "done one cycle", done, 0);
    end else begin
      chk(done == 1'b0, "R9", "no done", done, 0);
      chk(addr_valid && addr_data == base, "R9", "reload", addr_data, base);
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk(!addr_valid && !busy && !done && !irq, "R1", "reset outputs",
        {addr_valid, busy, done, irq}, 0);
  endtask

  task automatic t_1d();
    do_reset();
    setup(32'h1000, 5, 7, 3, -100, 0, 0, 0, 0);
    pulse_start();
    walk("R6", 5, 1, 1, -1, -1);
  endtask

  task automatic t_2d_rows();
    do_reset();
    setup(32'h2000_0100, 3, 4, 4, -11, 1, 1, 0, 1);
    pulse_start();
    walk("R5", 3, 4, 1, -1, -1);
  endtask

  task automatic t_auto();
    do_reset();
    setup(32'h0000_4000, 4, 3, 1, 0, 2, 1, 1, 0);
    pulse_start();
    walk("R9", 4, 3, 2, -1, -1);
  endtask

  task automatic t_bp();
    do_reset();
    setup(32'h0000_0800, 4, 1, -2, 0, 1, 0, 0, 0);
    pulse_start();
    walk("R4", 4, 1, 1, 2, -1);
  endtask

  task automatic t_restart();
    do_reset();
    setup(32'h0300_0000, 3, 2, 2, 5, 2, 1, 1, 1);
    pulse_start();
    walk("R12", 3, 2, 2, -1, 2);
  endtask

  task automatic t_zero();
    do_reset();
    setup(32'h0, 0, 0, 1, 0, 0, 0, 0, 0);
    pulse_start();
    walk("R7", 65536, 1, 1, -1, -1);
  endtask

  initial begin
    t_reset();
    t_1d();
    t_2d_rows();
    t_auto();
    t_bp();
    t_restart();
    t_zero();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1_500_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule